// File: doc/BRIEF.md
# Passive Serial Configuration Master

This block loads a downstream programmable device over a two-wire serial link: one data line and one configuration clock. A single-cycle start pulse begins a run. The block pulls the active-low configuration request line low to hold the target in reset. It waits for the target's status and completion inputs to read low, then holds reset for a programmable settle time and releases the line. It then polls the status input at a fixed interval until the target reports that it is ready.

The image is fetched one byte at a time from a synchronous read port with a one-cycle latency. Reads start at a base address and move upward. Each byte is shifted out most-significant bit first, with one clock pulse per bit. After every byte the block decides whether to stop. Reaching the end of the image window ends the run as a failure. Otherwise, a high completion input starts a run of extra clock pulses for target initialization, after which the run ends as a success.

Each wait for a level on an input is bounded by a timeout. When a timeout expires, the run is aborted and the reset line is left released. Software sees only start, busy and three result flags.

Top module: `ps_cfg_master`

## Requirements
- R1: After reset, and whenever the block is not busy, `cfg_n_o` is high, `dclk_o` is low and `busy_o` is low. A start pulse is accepted only when not busy; a start pulse while busy does not begin a second reset of the target.
- R2: On an accepted start, `cfg_n_o` goes low while `dclk_o` stays low, and the block waits until `status_i` and `conf_done_i` both read 0.
- R3: Once both inputs read 0, `cfg_n_o` stays low for at least `SETTLE_CYC` more cycles before it goes high.
- R4: After release, `status_i` is sampled every `POLL_CYC` cycles. No clock pulse is issued before it reads 1.
- R5: `mem_rd_o` reads addresses `START_ADDR`, `START_ADDR+1`, ... in order, one at a time, with the data taken the cycle after the read. No read is made at or beyond `END_ADDR`.
- R6: Each byte produces 8 clock pulses, each `HALF_CYC` cycles low and then `HALF_CYC` cycles high. Bit 7 goes first. `data_o` changes only together with a falling clock edge, so it is stable for `HALF_CYC` cycles before each rising edge.
- R7: After a byte, if the next address would equal `END_ADDR`, the run ends with `err_o`=1 and `tmo_o`=0 and issues no extra pulses, even if `conf_done_i` is 1.
- R8: After a byte that is not the last, if `conf_done_i` is 1, exactly `TRAIL_PULSES` more pulses are issued and the run ends with `ok_o`=1. If it is 0, the next byte is fetched.
- R9: If the wait in R2 or the ready poll in R4 lasts `TMO_CYC` cycles, the run aborts with `err_o`=1 and `tmo_o`=1. `cfg_n_o` is left high and no clock pulse is issued.
- R10: `busy_o` is high from the cycle after acceptance until the result flags are set. The flags stay constant until the next accepted start. `ok_o` and `err_o` are never both 1, and `tmo_o` implies `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request to begin a run |
| busy_o | output | 1 | Run in progress |
| ok_o | output | 1 | Last run finished successfully |
| err_o | output | 1 | Last run failed |
| tmo_o | output | 1 | Last run failed because a wait timed out |
| mem_rd_o | output | 1 | Read strobe to the image memory |
| mem_addr_o | output | AW | Byte address of the read |
| mem_data_i | input | 8 | Read data, valid the cycle after the strobe |
| cfg_n_o | output | 1 | Active-low reset/configuration request to the target |
| dclk_o | output | 1 | Configuration clock; target samples on its rising edge |
| data_o | output | 1 | Serial configuration data |
| status_i | input | 1 | Target status; high means ready |
| conf_done_i | input | 1 | Target reports the full image received |

## Verification
The bench builds the block with a four-byte window (16 up to 20) on a 12-bit address and a two-cycle half period. The settle time is 6 cycles, the poll interval 3 cycles, the timeout 40 cycles and the trailer 5 pulses. With these values, every way a run can end fits in a few hundred cycles: completion after the first, second or third byte, completion on the last byte where the bound takes priority, no completion at all, and both kinds of timeout. The real 1 MiB window and 4000-pulse trailer only stretch the same counters.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HOLD,
    ST_SETTLE,
    ST_POLL,
    ST_FETCH,
    ST_LOAD,
    ST_SHIFT,
    ST_CHECK,
    ST_TRAIL
  } cfg_state_e;

  // width able to hold the value v
  function automatic int bits_for(input int v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ps_cfg_timer.sv
module ps_cfg_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/ps_cfg_serial.sv
module ps_cfg_serial #(
  parameter int HALF_CYC = 2,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic             shift_i,
  input  logic [7:0]       byte_i,
  input  logic [CNT_W-1:0] npulse_i,
  output logic             dclk_o,
  output logic             data_o,
  output logic             fin_o
);

  import ps_cfg_pkg::*;

  localparam int HW = bits_for(HALF_CYC);
  localparam logic [HW-1:0] HALF_M1 = HW'(HALF_CYC - 1);

  logic [6:0]       rest_q;
  logic [CNT_W-1:0] left_q;
  logic [HW-1:0]    ph_q;
  logic             run_q;
  logic             mode_shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rest_q       <= '0;
      left_q       <= '0;
      ph_q         <= '0;
      run_q        <= 1'b0;
      mode_shift_q <= 1'b0;
      dclk_o       <= 1'b0;
      data_o       <= 1'b0;
      fin_o        <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (go_i) begin
        mode_shift_q <= shift_i;
        left_q       <= npulse_i;
        ph_q         <= HALF_M1;
        dclk_o       <= 1'b0;
        run_q        <= (npulse_i != '0);
        if (shift_i) begin
          data_o <= byte_i[7];
          rest_q <= byte_i[6:0];
        end
      end else if (run_q) begin
        if (ph_q != '0) begin
          ph_q <= ph_q - HW'(1);
        end else if (!dclk_o) begin
          dclk_o <= 1'b1;
          ph_q   <= HALF_M1;
        end else begin
          dclk_o <= 1'b0;
          ph_q   <= HALF_M1;
          if (left_q == CNT_W'(1)) begin
            run_q <= 1'b0;
            fin_o <= 1'b1;
          end else begin
            left_q <= left_q - CNT_W'(1);
            if (mode_shift_q) begin
              data_o <= rest_q[6];
              rest_q <= {rest_q[5:0], 1'b0};
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/ps_cfg_master.sv
module ps_cfg_master #(
  parameter int          AW           = 24,
  parameter int unsigned START_ADDR   = 32'h0070_0000,
  parameter int unsigned END_ADDR     = 32'h0080_0000,
  parameter int          SETTLE_CYC   = 1000,
  parameter int          POLL_CYC     = 1000,
  parameter int          HALF_CYC     = 4,
  parameter int          TMO_CYC      = 1000000,
  parameter int          TRAIL_PULSES = 4000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          busy_o,
  output logic          ok_o,
  output logic          err_o,
  output logic          tmo_o,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [7:0]    mem_data_i,
  output logic          cfg_n_o,
  output logic          dclk_o,
  output logic          data_o,
  input  logic          status_i,
  input  logic          conf_done_i
);

  import ps_cfg_pkg::*;

  localparam logic [AW-1:0] START_A = AW'(START_ADDR);
  localparam logic [AW-1:0] END_A   = AW'(END_ADDR);
  localparam int WW    = bits_for(max2(SETTLE_CYC, POLL_CYC));
  localparam int TW    = bits_for(TMO_CYC);
  localparam int CNT_W = bits_for(max2(TRAIL_PULSES, 8));

  function automatic logic [AW-1:0] addr_step(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic is_last(input logic [AW-1:0] a);
    return addr_step(a) == END_A;
  endfunction

  cfg_state_e      state_q, state_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic            cfgn_d;
  logic            wt_load, tmo_load, wt_exp, tmo_exp;
  logic [WW-1:0]   wt_val;
  logic            ser_go, ser_shift, ser_fin;
  logic [CNT_W-1:0] ser_n;
  logic            fin_ok, fin_err, fin_tmo;

  // named events
  logic accept_w, both_low_w, ready_w, byte_end_w, last_byte_w, abort_w;

  assign accept_w    = (state_q == ST_IDLE) && start_i;
  assign both_low_w  = (state_q == ST_HOLD) && !status_i && !conf_done_i;
  assign ready_w     = (state_q == ST_POLL) && wt_exp && status_i;
  assign byte_end_w  = (state_q == ST_CHECK);
  assign last_byte_w = is_last(addr_q);
  assign abort_w     = tmo_exp && (((state_q == ST_HOLD) && !both_low_w) ||
                                   ((state_q == ST_POLL) && !ready_w));

  ps_cfg_timer #(.W(WW)) u_wait (
    .clk(clk), .rst_n(rst_n), .load_i(wt_load), .val_i(wt_val), .expired_o(wt_exp)
  );

  ps_cfg_timer #(.W(TW)) u_tmo (
    .clk(clk), .rst_n(rst_n), .load_i(tmo_load), .val_i(TW'(TMO_CYC)), .expired_o(tmo_exp)
  );

  ps_cfg_serial #(.HALF_CYC(HALF_CYC), .CNT_W(CNT_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .go_i(ser_go), .shift_i(ser_shift),
    .byte_i(mem_data_i), .npulse_i(ser_n),
    .dclk_o(dclk_o), .data_o(data_o), .fin_o(ser_fin)
  );

  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    cfgn_d    = cfg_n_o;
    wt_load   = 1'b0;
    wt_val    = WW'(POLL_CYC);
    tmo_load  = 1'b0;
    ser_go    = 1'b0;
    ser_shift = 1'b0;
    ser_n     = CNT_W'(8);
    fin_ok    = 1'b0;
    fin_err   = 1'b0;
    fin_tmo   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept_w) begin
          cfgn_d   = 1'b0;
          tmo_load = 1'b1;
          addr_d   = START_A;
          state_d  = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (both_low_w) begin
          wt_load = 1'b1;
          wt_val  = WW'(SETTLE_CYC);
          state_d = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (wt_exp) begin
          cfgn_d   = 1'b1;
          wt_load  = 1'b1;
          tmo_load = 1'b1;
          state_d  = ST_POLL;
        end
      end
      ST_POLL: begin
        if (ready_w) begin
          state_d = ST_FETCH;
        end else if (wt_exp) begin
          wt_load = 1'b1;
        end
      end
      ST_FETCH: state_d = ST_LOAD;
      ST_LOAD: begin
        ser_go    = 1'b1;
        ser_shift = 1'b1;
        state_d   = ST_SHIFT;
      end
      ST_SHIFT: begin
        if (ser_fin) state_d = ST_CHECK;
      end
      ST_CHECK: begin
        addr_d = addr_step(addr_q);
        if (last_byte_w) begin
          fin_err = 1'b1;
          state_d = ST_IDLE;
        end else if (conf_done_i) begin
          if (TRAIL_PULSES == 0) begin
            fin_ok  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            ser_go  = 1'b1;
            ser_n   = CNT_W'(TRAIL_PULSES);
            state_d = ST_TRAIL;
          end
        end else begin
          state_d = ST_FETCH;
        end
      end
      ST_TRAIL: begin
        if (ser_fin) begin
          fin_ok  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (abort_w) begin
      cfgn_d  = 1'b1;
      fin_err = 1'b1;
      fin_tmo = 1'b1;
      state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      cfg_n_o <= 1'b1;
      busy_o  <= 1'b0;
      ok_o    <= 1'b0;
      err_o   <= 1'b0;
      tmo_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      cfg_n_o <= cfgn_d;
      if (accept_w) begin
        busy_o <= 1'b1;
        ok_o   <= 1'b0;
        err_o  <= 1'b0;
        tmo_o  <= 1'b0;
      end else if (fin_ok || fin_err) begin
        busy_o <= 1'b0;
        ok_o   <= fin_ok;
        err_o  <= fin_err;
        tmo_o  <= fin_tmo;
      end
    end
  end

  assign mem_rd_o   = (state_q == ST_FETCH);
  assign mem_addr_o = addr_q;

endmodule

// File: rtl/ps_cfg_master_chk.sv
module ps_cfg_master_chk #(
  parameter int          AW         = 24,
  parameter int unsigned START_ADDR = 0,
  parameter int unsigned END_ADDR   = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          ok_o,
  input logic          err_o,
  input logic          tmo_o,
  input logic          mem_rd_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          cfg_n_o,
  input logic          dclk_o,
  input logic          data_o,
  input logic          byte_end_w,
  input logic          last_byte_w
);

  localparam logic [AW-1:0] LO = AW'(START_ADDR);
  localparam logic [AW-1:0] HI = AW'(END_ADDR);

  // R10
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(ok_o && err_o));

  // R10
  tmo_err_chk: assert property (@(posedge clk) disable iff (!rst_n) tmo_o |-> err_o);

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(ok_o) && $stable(err_o) && $stable(tmo_o)));

  // R6
  data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk_o) |-> $stable(data_o));

  // R2
  quiet_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_n_o |-> !dclk_o);

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (cfg_n_o && !dclk_o));

  // R5
  addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> (mem_addr_o >= LO && mem_addr_o < HI));

  // R7
  bound_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end_w && last_byte_w) |=> (err_o && !tmo_o && !busy_o));

  // R9
  tmo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_o) |-> cfg_n_o);

endmodule

bind ps_cfg_master ps_cfg_master_chk #(
  .AW(AW), .START_ADDR(START_ADDR), .END_ADDR(END_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .ok_o(ok_o), .err_o(err_o), .tmo_o(tmo_o), .mem_rd_o(mem_rd_o),
  .mem_addr_o(mem_addr_o), .cfg_n_o(cfg_n_o), .dclk_o(dclk_o),
  .data_o(data_o), .byte_end_w(byte_end_w), .last_byte_w(last_byte_w)
);

// File: tb/tb_ps_cfg_master.sv
module tb_ps_cfg_master;

  localparam int AW = 12;
  localparam int START = 16;
  localparam int ENDB = 20;
  localparam int SETTLE = 6;
  localparam int POLL = 3;
  localparam int HALF = 2;
  localparam int TMO = 40;
  localparam int TRAIL = 5;

  typedef struct packed {
    logic       stuck;
    logic [7:0] stat_dly;   // 255: never ready
    logic [7:0] done_bits;  // 0: never done
    logic       e_ok;
    logic       e_err;
    logic       e_tmo;
    logic [7:0] e_pulses;
    logic [3:0] e_bytes;
    logic       midstart;
  } scen_t;

  localparam int NSC = 7;
  localparam scen_t TBL [NSC] = '{
    '{1'b0, 8'd5,   8'd16, 1'b1, 1'b0, 1'b0, 8'd21, 4'd2, 1'b0},  // R8 done after 2nd byte
    '{1'b0, 8'd2,   8'd8,  1'b1, 1'b0, 1'b0, 8'd13, 4'd1, 1'b1},  // R8 + R1 start while busy
    '{1'b0, 8'd5,   8'd0,  1'b0, 1'b1, 1'b0, 8'd32, 4'd4, 1'b0},  // R7 never done
    '{1'b0, 8'd5,   8'd32, 1'b0, 1'b1, 1'b0, 8'd32, 4'd4, 1'b0},  // R7 done on last byte
    '{1'b0, 8'd255, 8'd0,  1'b0, 1'b1, 1'b1, 8'd0,  4'd0, 1'b0},  // R9 never ready
    '{1'b1, 8'd5,   8'd0,  1'b0, 1'b1, 1'b1, 8'd0,  4'd0, 1'b0},  // R9 stuck in reset wait
    '{1'b0, 8'd4,   8'd24, 1'b1, 1'b0, 1'b0, 8'd29, 4'd3, 1'b0}   // R8 done after 3rd byte
  };

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic busy_o, ok_o, err_o, tmo_o, mem_rd_o, cfg_n_o, dclk_o, data_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0] mem_data_i = 8'h00;
  logic status_i = 1'b1, conf_done_i = 1'b0;

  always #2 clk = ~clk;

  ps_cfg_master #(
    .AW(AW), .START_ADDR(START), .END_ADDR(ENDB), .SETTLE_CYC(SETTLE),
    .POLL_CYC(POLL), .HALF_CYC(HALF), .TMO_CYC(TMO), .TRAIL_PULSES(TRAIL)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .ok_o(ok_o),
    .err_o(err_o), .tmo_o(tmo_o), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
    .mem_data_i(mem_data_i), .cfg_n_o(cfg_n_o), .dclk_o(dclk_o), .data_o(data_o),
    .status_i(status_i), .conf_done_i(conf_done_i)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29) + 71);
  endfunction

  // memory and target models
  logic       sc_stuck = 1'b0;
  logic [7:0] sc_dly = 8'd0, sc_done = 8'd0;
  int sdly = 0, rises = 0;
  logic dclk_q = 1'b0;

  always @(posedge clk) begin
    if (mem_rd_o) mem_data_i <= pat(int'(mem_addr_o));
    dclk_q <= dclk_o;
    if (!cfg_n_o) begin
      status_i    <= sc_stuck;
      conf_done_i <= sc_stuck;
      rises <= 0;
      sdly  <= 0;
    end else begin
      if (!status_i) begin
        if (sc_dly != 8'd255 && sdly >= int'(sc_dly)) status_i <= 1'b1;
        sdly <= sdly + 1;
      end
      if (dclk_o && !dclk_q) begin
        rises <= rises + 1;
        if (sc_done != 8'd0 && rises + 1 == int'(sc_done)) conf_done_i <= 1'b1;
      end
    end
  end

  // port monitors (negedge)
  int n_pulses, n_badclk, n_unstable, n_badbyte, n_bytes, n_reads, n_badaddr;
  int n_cfgfall, n_lowquiet, since_chg, bitc;
  logic [7:0] cur;
  logic data_p = 1'b0, dclk_p = 1'b0, cfgn_p = 1'b1;

  task automatic clr_mon();
    n_pulses = 0; n_badclk = 0; n_unstable = 0; n_badbyte = 0; n_bytes = 0;
    n_reads = 0; n_badaddr = 0; n_cfgfall = 0; n_lowquiet = 0; bitc = 0; cur = 8'h00;
  endtask

  always @(negedge clk) begin
    if (data_o != data_p) since_chg = 0; else since_chg = since_chg + 1;
    if (dclk_o && !dclk_p) begin
      n_pulses = n_pulses + 1;
      if (!status_i) n_badclk = n_badclk + 1;
      if (since_chg < HALF) n_unstable = n_unstable + 1;
      cur = {cur[6:0], data_o};
      bitc = bitc + 1;
      if (bitc == 8) begin
        if (n_bytes < ENDB - START && cur != pat(START + n_bytes)) n_badbyte = n_badbyte + 1;
        n_bytes = n_bytes + 1;
        bitc = 0;
      end
    end
    if (mem_rd_o) begin
      if (int'(mem_addr_o) != START + n_reads) n_badaddr = n_badaddr + 1;
      n_reads = n_reads + 1;
    end
    if (!cfg_n_o && cfgn_p) n_cfgfall = n_cfgfall + 1;
    if (!cfg_n_o && !status_i && !conf_done_i) n_lowquiet = n_lowquiet + 1;
    data_p = data_o; dclk_p = dclk_o; cfgn_p = cfg_n_o;
  end

  int n_chk = 0, n_bad = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input scen_t s, input int idx);
    int guard;
    clr_mon();
    sc_stuck = s.stuck; sc_dly = s.stat_dly; sc_done = s.done_bits;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check("R10 busy after accept", int'(busy_o), 1);
    guard = 0;
    while (busy_o && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (s.midstart && guard == 30) start_i = 1'b1;
      else start_i = 1'b0;
    end
    start_i = 1'b0;
    check("R10 run ends", int'(guard < 5000), 1);
    $display("scenario %0d", idx);
    check("R8/R10 ok flag", int'(ok_o), int'(s.e_ok));
    check("R7/R9 err flag", int'(err_o), int'(s.e_err));
    check("R9 tmo flag", int'(tmo_o), int'(s.e_tmo));
    check("R6/R7/R8 pulse count", n_pulses, int'(s.e_pulses));
    check("R6 bytes msb first", n_badbyte, 0);
    check("R6 data setup", n_unstable, 0);
    check("R4 no clock before ready", n_badclk, 0);
    check("R5 reads", n_reads, int'(s.e_bytes));
    check("R5 addresses", n_badaddr, 0);
    check("R1 one reset entry", n_cfgfall, 1);
    if (!s.stuck && s.stat_dly != 8'd255)
      check("R3 settle", int'(n_lowquiet >= SETTLE), 1);
    check("R1/R9 cfg released", int'(cfg_n_o), 1);
    repeat (12) @(negedge clk);
    check("R10 flags held", int'({ok_o, err_o, tmo_o}), int'({s.e_ok, s.e_err, s.e_tmo}));
    check("R1 clock idle", int'(dclk_o), 0);
  endtask

  int wd = 0;
  always @(negedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    clr_mon();
    since_chg = 0;
    repeat (3) @(negedge clk);
    check("R1 reset cfg", int'(cfg_n_o), 1);
    check("R1 reset dclk", int'(dclk_o), 0);
    check("R1 reset flags", int'({busy_o, ok_o, err_o, tmo_o}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle busy", int'(busy_o), 0);
    for (int i = 0; i < NSC; i++) run(TBL[i], i);
    // R1: reset mid-run returns to idle lines
    clr_mon();
    sc_stuck = 1'b0; sc_dly = 8'd3; sc_done = 8'd0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", int'({busy_o, cfg_n_o, dclk_o}), 3'b010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(TBL[0], 99);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule